// File: doc/BRIEF.md
# Registered Bidirectional Bus Translator

This block bridges two parallel buses, the A-side and the B-side, through one shared data register. A single direction input selects which side is the source and which is the destination. On each rising clock edge the register takes the word present on the source side. The register contents are presented on the destination side whenever the output enable is high. The source side is never driven by the block.

When the output enable is low, the block drives neither bus, but the register keeps capturing on every clock edge. The B-side then floats. The A-side enters a cut-off condition that is reported on its own flag, separate from any logic level on the A data lines. A direction change acts on the drivers at once: the side that was driving lets go, and the other side shows the stored word without waiting for a clock. An active-low synchronous reset clears the register.

Top module: `bidir_xlat_reg`

## Requirements
- R1: With `dir_b_to_a` = 0, each rising clock edge loads the register from `a_io`, and `b_io` presents the register when `oe` = 1.
- R2: With `dir_b_to_a` = 1, each rising clock edge loads the register from `b_io`, and `a_io` presents the register when `oe` = 1.
- R3: With `oe` = 0, the block drives neither `a_io` nor `b_io`, and `a_cutoff` is 1, for either direction.
- R4: `a_cutoff` is 0 exactly when the A-side is being driven (`oe` = 1 and `dir_b_to_a` = 1), and 1 otherwise.
- R5: Between rising edges, changing the source-side data has no effect on the presented value.
- R6: The register keeps loading while `oe` = 0. Raising `oe` presents the most recently captured word with no further clock.
- R7: The source side is never driven by the block, so a value driven onto it from outside reads back unchanged.
- R8: A change of `dir_b_to_a` moves the driver to the other side in the same cycle, with the current register value and no clock edge needed.
- R9: `rst_n` = 0 at a rising edge clears the register to all zeros, whatever the source-side data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low register clear |
| dir_b_to_a | input | 1 | 0: A is source and B is destination; 1: B is source and A is destination |
| oe | input | 1 | Active-high output enable for the destination side |
| a_io | inout | DATA_W | A-side data bus |
| b_io | inout | DATA_W | B-side data bus |
| a_cutoff | output | 1 | High whenever the A-side is not driven |

## Verification
The bench covers every direction and enable pairing with a set of data words. Each time the block should leave a bus alone, the bench drives that bus with a probe value and reads it back. A design that drove a released or source side would corrupt the probe instead of letting it pass through. Further cases load the register while the outputs are disabled and then enable them without a clock; a design that gated loading on the enable would show a stale word. The bench also flips the direction between edges, which catches a design that waits a cycle to move its driver. It changes source data between edges to expose capture that is transparent rather than edge-triggered. Resets land in the middle of the run with nonzero data on the source side, so a reset that does not clear, or that lets the capture through, shows up at the ports.

// File: rtl/bxr_pkg.sv
// Package: shared definitions for the registered bus translator.
// Assumes a single clock domain; the flow encoding matches the dir input.
package bxr_pkg;
    typedef enum logic {
        FLOW_A_TO_B = 1'b0,
        FLOW_B_TO_A = 1'b1
    } flow_e;
endpackage

// File: rtl/bxr_capture_reg.sv
// Module: shared data register. It loads from the side picked by the flow
// on every rising clock edge and clears on a synchronous active-low reset.
// Assumes both bus inputs are settled before the edge.
module bxr_capture_reg
    import bxr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  flow_e        flow,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] q
);
    logic [W-1:0] next_word;

    // Pick the source side for the next capture.
    always_comb begin
        next_word = (flow == FLOW_B_TO_A) ? b_in : a_in;
    end

    // Load on every edge; the enable does not gate capture.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= next_word;
    end
endmodule

// File: rtl/bxr_steer.sv
// Module: driver steering. From the flow and the output enable it decides
// which side, if any, is driven, and flags A-side cut-off. Purely
// combinational, so a direction change acts within the same cycle.
module bxr_steer
    import bxr_pkg::*;
(
    input  flow_e flow,
    input  logic  oe,
    output logic  drive_a,
    output logic  drive_b,
    output logic  cutoff_a
);
    // Only the destination side may drive, and only while enabled.
    always_comb begin
        drive_a  = oe && (flow == FLOW_B_TO_A);
        drive_b  = oe && (flow == FLOW_A_TO_B);
        cutoff_a = !drive_a;
    end
endmodule

// File: rtl/bidir_xlat_reg.sv
// Module: registered bidirectional bus translator (top). A single register
// moves words from the source side to the destination side. Assumes the
// outside world does not drive the destination side while it is enabled.
module bidir_xlat_reg
    import bxr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_b_to_a,
    input  logic              oe,
    inout  wire  [DATA_W-1:0] a_io,
    inout  wire  [DATA_W-1:0] b_io,
    output logic              a_cutoff
);
    flow_e             flow;
    logic [DATA_W-1:0] data_q;
    logic              drive_a;
    logic              drive_b;

    // Map the direction pin onto the flow encoding.
    always_comb begin
        flow = dir_b_to_a ? FLOW_B_TO_A : FLOW_A_TO_B;
    end

    bxr_capture_reg #(.W(DATA_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .flow  (flow),
        .a_in  (a_io),
        .b_in  (b_io),
        .q     (data_q)
    );

    bxr_steer u_steer (
        .flow     (flow),
        .oe       (oe),
        .drive_a  (drive_a),
        .drive_b  (drive_b),
        .cutoff_a (a_cutoff)
    );

    // Tri-state pads: the register drives only the selected, enabled side.
    assign a_io = drive_a ? data_q : {DATA_W{1'bz}};
    assign b_io = drive_b ? data_q : {DATA_W{1'bz}};
endmodule

// File: rtl/bxr_checker.sv
// Module: assertion checker for bidir_xlat_reg, attached by bind.
// Assumes the bench never drives the enabled destination side.
module bxr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         dir_b_to_a,
    input logic         oe,
    input logic [W-1:0] a_io,
    input logic [W-1:0] b_io,
    input logic         a_cutoff,
    input logic [W-1:0] data_q
);
    assert_a_source_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(dir_b_to_a)) |-> (data_q == $past(a_io)));

    assert_b_source_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dir_b_to_a)) |-> (data_q == $past(b_io)));

    assert_b_presents_reg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !dir_b_to_a) |-> (b_io == data_q));

    assert_a_presents_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && dir_b_to_a) |-> (a_io == data_q));

    assert_disabled_cutoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> a_cutoff);

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (data_q == '0));
endmodule

bind bidir_xlat_reg bxr_checker #(.W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_b_to_a (dir_b_to_a),
    .oe         (oe),
    .a_io       (a_io),
    .b_io       (b_io),
    .a_cutoff   (a_cutoff),
    .data_q     (data_q)
);

// File: tb/tb_bidir_xlat_reg.sv
module tb_bidir_xlat_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_b_to_a = 1'b0;
    logic       oe = 1'b0;
    logic [7:0] drv_a = 8'h00;
    logic [7:0] drv_b = 8'h00;
    logic       en_a = 1'b0;
    logic       en_b = 1'b0;
    wire  [7:0] a_io;
    wire  [7:0] b_io;
    wire        a_cutoff;
    logic [7:0] mdl = 8'h00;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign a_io = en_a ? drv_a : 8'hzz;
    assign b_io = en_b ? drv_b : 8'hzz;

    bidir_xlat_reg #(.DATA_W(8)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_b_to_a (dir_b_to_a),
        .oe         (oe),
        .a_io       (a_io),
        .b_io       (b_io),
        .a_cutoff   (a_cutoff)
    );

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Bench drives every side the block should leave alone.
    task automatic setup(input logic f, input logic o, input logic [7:0] a, input logic [7:0] b);
        dir_b_to_a = f;
        oe         = o;
        drv_a      = a;
        drv_b      = b;
        en_a       = !(o && f);
        en_b       = !(o && !f);
    endtask

    // Compare both buses and the flag against the model.
    task automatic check_ports(input string tag);
        logic a_drv;
        logic b_drv;
        a_drv = oe && dir_b_to_a;
        b_drv = oe && !dir_b_to_a;
        chk1({"R4 ", tag}, a_cutoff, !a_drv);
        if (a_drv) chk8({"R2 ", tag}, a_io, mdl);
        else       chk8({"R3/R7 A released ", tag}, a_io, drv_a);
        if (b_drv) chk8({"R1 ", tag}, b_io, mdl);
        else       chk8({"R3/R7 B released ", tag}, b_io, drv_b);
    endtask

    // One full cycle: inputs set at a falling edge, checked at the next.
    task automatic step(input logic f, input logic o, input logic [7:0] a, input logic [7:0] b, input string tag);
        setup(f, o, a, b);
        @(posedge clk);
        mdl = !rst_n ? 8'h00 : (f ? b : a);
        @(negedge clk);
        check_ports(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R9: reset with live source data clears the register
        step(1'b0, 1'b1, 8'hA5, 8'h00, "R9 reset");
        step(1'b0, 1'b1, 8'h5A, 8'h00, "R9 reset hold");
        chk8("R9 cleared", b_io, 8'h00);
        rst_n = 1'b1;

        // Sweep of every direction and enable pairing.
        for (int f = 0; f < 2; f++) begin
            for (int o = 0; o < 2; o++) begin
                for (int k = 0; k < 8; k++) begin
                    logic [7:0] av;
                    logic [7:0] bv;
                    av = 8'(k * 37 + 11 + f * 64 + o * 5);
                    bv = ~av ^ 8'(k);
                    step(f[0], o[0], av, bv, "sweep");
                end
            end
        end

        // R5: source data changes between edges do not reach the output
        step(1'b0, 1'b1, 8'h3C, 8'h00, "R5 load");
        setup(1'b0, 1'b1, 8'hC3, 8'h00);
        #5;
        chk8("R5 no edge, no change", b_io, 8'h3C);
        @(posedge clk);
        mdl = 8'hC3;
        @(negedge clk);
        check_ports("R5 after edge");

        // R6: loads continue while disabled; enable shows newest word
        step(1'b0, 1'b0, 8'h11, 8'hEE, "R6 disabled load 1");
        step(1'b0, 1'b0, 8'h22, 8'hDD, "R6 disabled load 2");
        step(1'b0, 1'b0, 8'h47, 8'hB8, "R6 disabled load 3");
        setup(1'b0, 1'b1, 8'h47, 8'h00);
        #5;
        chk8("R6 enable shows latest", b_io, 8'h47);
        chk1("R6 cutoff with B out", a_cutoff, 1'b1);
        @(posedge clk);
        @(negedge clk);

        // R8: direction flip moves the driver without a clock
        step(1'b0, 1'b1, 8'h9E, 8'h00, "R8 load");
        setup(1'b1, 1'b1, 8'h00, 8'h61);
        #5;
        chk8("R8 A shows register", a_io, 8'h9E);
        chk1("R8 cutoff released", a_cutoff, 1'b0);
        chk8("R8 B released", b_io, 8'h61);
        @(posedge clk);
        mdl = 8'h61;
        @(negedge clk);
        check_ports("R8 after edge");
        setup(1'b0, 1'b1, 8'h0F, 8'h00);
        #5;
        chk8("R8 flip back B shows register", b_io, 8'h61);
        chk1("R8 cutoff back", a_cutoff, 1'b1);
        @(posedge clk);
        mdl = 8'h0F;
        @(negedge clk);
        check_ports("R8 flip back edge");

        // R9: mid-run reset with B as source
        rst_n = 1'b0;
        step(1'b1, 1'b1, 8'h00, 8'hFF, "R9 mid-run reset");
        rst_n = 1'b1;
        step(1'b1, 1'b1, 8'h00, 8'h81, "R2 after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule